// File: doc/BRIEF.md
# CAN Error State Flag Unit

This block keeps the transmit and receive error counters of a CAN node and turns them into an 8-bit error status word. It also raises a one-cycle interrupt pulse whenever the node's fault confinement state moves. The protocol engine sends it pulses that add a given amount to a counter, take one away, or load a value. It sees the arrival of a good frame for each receive buffer, together with that buffer's full flag. The host clears the overflow indications with strobes. The bus-off recovery logic reports a completed recovery sequence.

The flags come straight from the counters, so they follow every counter update within the same cycle. The one exception is bus-off, which is held once reached. Detection of protocol errors is done elsewhere.

Top module: `can_err_state`

## Requirements
- R1: Each counter changes one clock after its pulse. Set loads `*_set_val_i`. Increment adds `*_inc_amt_i` and saturates at 255. Decrement subtracts 1 and stays at 0 when the counter is already 0. When pulses coincide, set wins over increment and increment wins over decrement.
- R2: `eflg_o[1]` is 1 exactly while rec_o >= 96. `eflg_o[2]` is 1 exactly while tec_o >= 96.
- R3: `eflg_o[0]` is 1 while either counter is >= 96. It returns to 0 only once both counters are below 96.
- R4: `eflg_o[3]` is 1 exactly while rec_o >= 128. `eflg_o[4]` is 1 exactly while tec_o >= 128.
- R5: `eflg_o[5]` (bus-off) becomes 1 in the cycle tec_o reads 255. It then stays 1, even if tec_o falls, until a recovery completes.
- R6: A `recov_done_i` pulse clears both counters and `eflg_o[5]` one clock later. It overrides every counter pulse in the same cycle.
- R7: `eflg_o[6+i]` sets one clock after `rx_valid_i[i]` arrives while `rx_full_i[i]` is 1. It holds until `ovr_clr_i[i]`. A valid frame with the buffer not full has no effect. If a set and a clear coincide, the set wins.
- R8: `err_irq_o` is 1 for exactly the first cycle in which any of `eflg_o[5:0]` shows a new value. Changes to the overflow bits do not raise it.
- R9: After reset, both counters, `eflg_o` and `err_irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_inc_i | input | 1 | Add tx_inc_amt_i to the transmit counter |
| tx_inc_amt_i | input | 8 | Transmit increment amount |
| tx_dec_i | input | 1 | Decrement the transmit counter by one |
| tx_set_i | input | 1 | Load tx_set_val_i into the transmit counter |
| tx_set_val_i | input | 8 | Transmit load value |
| rx_inc_i | input | 1 | Add rx_inc_amt_i to the receive counter |
| rx_inc_amt_i | input | 8 | Receive increment amount |
| rx_dec_i | input | 1 | Decrement the receive counter by one |
| rx_set_i | input | 1 | Load rx_set_val_i into the receive counter |
| rx_set_val_i | input | 8 | Receive load value |
| rx_valid_i | input | 2 | Valid frame arrived for receive buffer i |
| rx_full_i | input | 2 | Receive buffer i still holds an unread frame |
| ovr_clr_i | input | 2 | Host clear of overflow flag i |
| recov_done_i | input | 1 | Bus-off recovery sequence completed |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| eflg_o | output | 8 | Error flag word |
| err_irq_o | output | 1 | One-cycle pulse on an error state change |

## Verification
A wrong counter value appears on tec_o or rec_o one clock after the pulse that caused it. The threshold flags are derived combinationally from the counters, so any mismatch between a count and its flags shows in that same cycle. A lost bus-off hold only becomes visible once the transmit counter drops below 255 without a recovery. The test therefore decrements after saturating. A missing or stretched interrupt shows in the cycle the flags move or in the cycle right after.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int EF_WARN   = 0;
  localparam int EF_RXWARN = 1;
  localparam int EF_TXWARN = 2;
  localparam int EF_RXPASS = 3;
  localparam int EF_TXPASS = 4;
  localparam int EF_BUSOFF = 5;
  localparam int EF_OVR0   = 6;
  localparam int EF_STATE_W = 6;

  typedef enum logic {CNT_TX = 1'b0, CNT_RX = 1'b1} cnt_sel_e;
endpackage

// File: rtl/can_err_counter.sv
module can_err_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         set_i,
  input  logic [W-1:0] set_val_i,
  input  logic         inc_i,
  input  logic [W-1:0] inc_amt_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;

  assign sum = {1'b0, cnt_q} + {1'b0, inc_amt_i};

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                    cnt_d = '0;
    else if (set_i)               cnt_d = set_val_i;
    else if (inc_i)               cnt_d = sum[W] ? MAX : sum[W-1:0];
    else if (dec_i && cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_no_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && !set_i && !clr_i && cnt_q == '0) |=> cnt_q == '0);
  p_saturate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !set_i && !clr_i && cnt_q == MAX) |=> cnt_q == MAX);
endmodule

// File: rtl/can_err_ovr.sv
module can_err_ovr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic full_i,
  input  logic clr_i,
  output logic ovr_o
);
  logic ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ovr_q <= 1'b0;
    else if (valid_i && full_i) ovr_q <= 1'b1;  // new event beats clear
    else if (clr_i)            ovr_q <= 1'b0;
  end

  assign ovr_o = ovr_q;

  p_ovr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !clr_i) |=> ovr_q);
  p_ovr_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && full_i) |=> ovr_q);
endmodule

// File: rtl/can_err_flags.sv
module can_err_flags
  import can_err_pkg::*;
#(
  parameter int W        = 8,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 128
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [W-1:0]          tec_i,
  input  logic [W-1:0]          rec_i,
  input  logic                  recov_i,
  output logic [EF_STATE_W-1:0] state_o,
  output logic                  irq_o
);
  localparam logic [W-1:0] MAX  = '1;
  localparam logic [W-1:0] WARN = W'(WARN_LVL);
  localparam logic [W-1:0] PASS = W'(PASS_LVL);

  logic                  bo_q;
  logic                  bo;
  logic [EF_STATE_W-1:0] st, prev_q;

  assign bo = bo_q | (tec_i == MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bo_q <= 1'b0;
    else if (recov_i) bo_q <= 1'b0;
    else              bo_q <= bo;
  end

  always_comb begin
    st            = '0;
    st[EF_RXWARN] = rec_i >= WARN;
    st[EF_TXWARN] = tec_i >= WARN;
    st[EF_WARN]   = st[EF_RXWARN] | st[EF_TXWARN];
    st[EF_RXPASS] = rec_i >= PASS;
    st[EF_TXPASS] = tec_i >= PASS;
    st[EF_BUSOFF] = bo;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= st;
  end

  assign state_o = st;
  assign irq_o   = st != prev_q;

  p_busoff_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st[EF_BUSOFF] && !recov_i) |=> st[EF_BUSOFF]);
  p_irq_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $stable(tec_i) && $stable(rec_i) && !recov_i) |=> !irq_o);
endmodule

// File: rtl/can_err_state.sv
module can_err_state
  import can_err_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int NBUF     = 2,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 128,
  localparam int FLAG_W  = EF_STATE_W + NBUF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_inc_i,
  input  logic [CNT_W-1:0]  tx_inc_amt_i,
  input  logic              tx_dec_i,
  input  logic              tx_set_i,
  input  logic [CNT_W-1:0]  tx_set_val_i,
  input  logic              rx_inc_i,
  input  logic [CNT_W-1:0]  rx_inc_amt_i,
  input  logic              rx_dec_i,
  input  logic              rx_set_i,
  input  logic [CNT_W-1:0]  rx_set_val_i,
  input  logic [NBUF-1:0]   rx_valid_i,
  input  logic [NBUF-1:0]   rx_full_i,
  input  logic [NBUF-1:0]   ovr_clr_i,
  input  logic              recov_done_i,
  output logic [CNT_W-1:0]  tec_o,
  output logic [CNT_W-1:0]  rec_o,
  output logic [FLAG_W-1:0] eflg_o,
  output logic              err_irq_o
);
  logic [1:0]             inc, dec, set;
  logic [1:0][CNT_W-1:0]  amt, val, cnt;
  logic [NBUF-1:0]        ovr;
  logic [EF_STATE_W-1:0]  st;

  assign inc = {rx_inc_i, tx_inc_i};
  assign dec = {rx_dec_i, tx_dec_i};
  assign set = {rx_set_i, tx_set_i};
  assign amt = {rx_inc_amt_i, tx_inc_amt_i};
  assign val = {rx_set_val_i, tx_set_val_i};

  for (genvar c = 0; c < 2; c++) begin : g_cnt
    can_err_counter #(.W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (recov_done_i),
      .set_i    (set[c]),
      .set_val_i(val[c]),
      .inc_i    (inc[c]),
      .inc_amt_i(amt[c]),
      .dec_i    (dec[c]),
      .cnt_o    (cnt[c])
    );
  end

  assign tec_o = cnt[CNT_TX];
  assign rec_o = cnt[CNT_RX];

  can_err_flags #(.W(CNT_W), .WARN_LVL(WARN_LVL), .PASS_LVL(PASS_LVL)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tec_i  (tec_o),
    .rec_i  (rec_o),
    .recov_i(recov_done_i),
    .state_o(st),
    .irq_o  (err_irq_o)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_ovr
    can_err_ovr u_ovr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(rx_valid_i[b]),
      .full_i (rx_full_i[b]),
      .clr_i  (ovr_clr_i[b]),
      .ovr_o  (ovr[b])
    );
  end

  assign eflg_o = {ovr, st};

  p_recov_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recov_done_i |=> (tec_o == '0 && rec_o == '0 && !eflg_o[EF_BUSOFF]));
endmodule

// File: tb/can_err_state_test.sv
module can_err_state_test;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT_CYC = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_inc = 0, tx_dec = 0, tx_set = 0;
  logic [7:0] tx_amt = 0, tx_val = 0;
  logic       rx_inc = 0, rx_dec = 0, rx_set = 0;
  logic [7:0] rx_amt = 0, rx_val = 0;
  logic [1:0] rx_valid = 0, rx_full = 0, ovr_clr = 0;
  logic       recov = 0;
  logic [7:0] tec, rec, eflg;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_err_state uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_inc_i(tx_inc), .tx_inc_amt_i(tx_amt), .tx_dec_i(tx_dec),
    .tx_set_i(tx_set), .tx_set_val_i(tx_val),
    .rx_inc_i(rx_inc), .rx_inc_amt_i(rx_amt), .rx_dec_i(rx_dec),
    .rx_set_i(rx_set), .rx_set_val_i(rx_val),
    .rx_valid_i(rx_valid), .rx_full_i(rx_full), .ovr_clr_i(ovr_clr),
    .recov_done_i(recov),
    .tec_o(tec), .rec_o(rec), .eflg_o(eflg), .err_irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expected state bits 5:0 from counters and held bus-off
  function automatic logic [7:0] exp_flags(input int t, input int r, input bit bo, input logic [1:0] ov);
    logic [7:0] f;
    f = '0;
    f[1] = r >= 96;  f[2] = t >= 96;  f[0] = f[1] | f[2];
    f[3] = r >= 128; f[4] = t >= 128; f[5] = bo;
    f[7:6] = ov;
    return f;
  endfunction

  // pulses are set at a negedge, applied at the posedge, cleared and sampled at next negedge
  task automatic tick();
    @(negedge clk);
    tx_inc = 0; tx_dec = 0; tx_set = 0; rx_inc = 0; rx_dec = 0; rx_set = 0;
    rx_valid = 0; rx_full = 0; ovr_clr = 0; recov = 0;
  endtask

  task automatic t_reset();
    chk("R9 tec", tec, 0); chk("R9 rec", rec, 0);
    chk("R9 eflg", eflg, 0); chk("R9 irq", irq, 0);
  endtask

  task automatic t_tx_warn();
    for (int i = 0; i < 12; i++) begin
      tx_inc = 1; tx_amt = 8; tick();
      if (i == 10) chk("R1 inc", tec, 88);
    end
    chk("R1 tec 96", tec, 96);
    chk("R2 R3 tx warn", eflg, exp_flags(96, 0, 0, 0));
    chk("R8 irq rise", irq, 1);
    tick();
    chk("R8 irq single", irq, 0);
  endtask

  task automatic t_rx_warn();
    rx_set = 1; rx_val = 100; tick();
    chk("R2 rx warn", eflg, exp_flags(96, 100, 0, 0));
    chk("R8 irq rx", irq, 1);
    rx_set = 1; rx_val = 95; tick();
    chk("R2 rx clear", eflg, exp_flags(96, 95, 0, 0));
    chk("R3 still set", eflg[0], 1);
    tx_set = 1; tx_val = 95; tick();
    chk("R3 both below", eflg, 0);
  endtask

  task automatic t_passive();
    rx_set = 1; rx_val = 128; tick();
    chk("R4 rx pass", eflg, exp_flags(95, 128, 0, 0));
    rx_set = 1; rx_val = 127; tick();
    chk("R4 rx pass clr", eflg, exp_flags(95, 127, 0, 0));
    tx_set = 1; tx_val = 130; tick();
    chk("R4 tx pass", eflg, exp_flags(130, 127, 0, 0));
  endtask

  task automatic t_busoff();
    tx_set = 1; tx_val = 250; tick();
    chk("R5 not yet", eflg[5], 0);
    tx_inc = 1; tx_amt = 8; tick();
    chk("R1 saturate", tec, 255);
    chk("R5 bus-off", eflg, exp_flags(255, 127, 1, 0));
    chk("R8 irq bo", irq, 1);
    tx_inc = 1; tx_amt = 1; tick();
    chk("R1 stay 255", tec, 255);
    tx_dec = 1; tick();
    chk("R1 dec", tec, 254);
    chk("R5 sticky", eflg[5], 1);
    chk("R8 no change", irq, 0);
  endtask

  task automatic t_priority();
    rx_set = 1; rx_val = 10; rx_inc = 1; rx_amt = 8; rx_dec = 1; tick();
    chk("R1 set wins", rec, 10);
    rx_inc = 1; rx_amt = 8; rx_dec = 1; tick();
    chk("R1 inc over dec", rec, 18);
    rx_set = 1; rx_val = 0; tick();
    rx_dec = 1; tick();
    chk("R1 no wrap", rec, 0);
  endtask

  task automatic t_recovery();
    tx_inc = 1; tx_amt = 8; rx_set = 1; rx_val = 50; recov = 1; tick();
    chk("R6 tec", tec, 0); chk("R6 rec", rec, 0);
    chk("R6 bus-off clr", eflg, 0);
    chk("R8 irq recov", irq, 1);
  endtask

  task automatic t_overflow();
    rx_valid = 2'b01; tick();
    chk("R7 not full", eflg[7:6], 0);
    rx_valid = 2'b01; rx_full = 2'b01; tick();
    chk("R7 set 0", eflg[7:6], 2'b01);
    chk("R8 no irq ovr", irq, 0);
    tick();
    chk("R7 hold", eflg[7:6], 2'b01);
    ovr_clr = 2'b01; tick();
    chk("R7 clear", eflg[7:6], 0);
    rx_valid = 2'b10; rx_full = 2'b10; ovr_clr = 2'b10; tick();
    chk("R7 set wins", eflg[7:6], 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_tx_warn();
    t_rx_warn();
    t_passive();
    t_busoff();
    t_priority();
    t_recovery();
    t_overflow();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (TIMEOUT_CYC) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule